// File: doc/BRIEF.md
# Watchdog Counter with Sticky Reset Status

This block is a watchdog. While it runs, an up-counter advances by one on every clock. Software must service it before it wraps. If the counter passes its top value while running, the block raises an internal chip reset for a fixed number of cycles. If software has enabled it, the block also drives an active-low reset pin so that external devices restart with the chip.

Two registers sit behind a small bus with a select line, read and write strobes, a 16-bit write word and 8-bit read data. A write counts only when its upper byte carries the key 0x5A.

The status register keeps a sticky flag that records a watchdog-caused reset. It also holds the external-output enable. Both bits survive the reset the watchdog itself generates, and only the external reset pin clears them. Software clears the flag with two steps: it first reads the register while the flag is set, then writes a 0 to the flag.

Top module: `wdt_rstctl`

## Requirements
- R1: While `ext_rst_n` is low and afterwards until new activity, the status register reads 0x3F, the counter reads 0, `chip_rst` is 0 and `rst_out_n` is 1.
- R2: The status register (`sel_stat`=1) reads as {flag in bit 7, output enable in bit 6, bits 5..0 all 1}.
- R3: While the run bit is set and no reset pulse is active, the counter (`sel_stat`=0, read data = count) rises by exactly one per clock. While the run bit is clear, the counter holds.
- R4: A control write (`sel_stat`=0) with `wdata[15:8]`=0x5A clears the counter and loads the run bit from `wdata[7]`. A control write with any other key has no effect.
- R5: When the counter is at 0xFF with the run bit set, the next edge starts a reset pulse: `chip_rst` is 1 for exactly 16 cycles and then returns to 0.
- R6: The overflow sets the flag (bit 7). The flag and the output enable keep their values through the reset pulse.
- R7: The reset pulse clears the counter and the run bit, and both stay cleared after the pulse ends.
- R8: `rst_out_n` is 0 during the reset pulse only when the output enable (bit 6) is 1. Otherwise it stays 1.
- R9: The flag clears only on a keyed status write with `wdata[7]`=0 that follows a status read which returned the flag as 1. A read made while the flag was 0 does not qualify a later write.
- R10: Writing 1 to bit 7 never sets the flag. Writing 0 to bit 7 without a qualifying read leaves the flag set.
- R11: Any status write, keyed or not, cancels a pending read qualification.
- R12: A keyed status write loads the output enable from `wdata[6]`. A status write with a wrong key leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous; the only reset that clears the status bits |
| sel_stat | input | 1 | Register select: 0 = counter/control, 1 = status |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 16 | Write word: key in [15:8], data in [7:0] |
| rdata | output | 8 | Read data of the selected register |
| chip_rst | output | 1 | Internal reset pulse, active high |
| rst_out_n | output | 1 | External reset output, active low |

## Verification
The bench goes after the clear protocol. It writes 0 to the flag with no read before it, with a read cancelled by a write that had a bad key, and with a read made before the flag rose. A design that clears on any zero write, that forgets to cancel the qualification, or that arms it while the flag is clear would drop the flag early. The bench counts the reset pulse cycle by cycle, so a pulse one cycle off in either direction shows up. It runs one overflow with the output enable on and one with it off, which catches a design that drives the external pin regardless of the enable, or one that loses the status bits in its own reset.

// File: rtl/wdt_rstctl.sv
module wdt_rstctl #(
  parameter int         CNT_W     = 8,
  parameter int         PULSE_LEN = 16,
  parameter logic [7:0] KEY       = 8'h5A
) (
  input  logic        clk,
  input  logic        ext_rst_n,
  input  logic        sel_stat,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [15:0] wdata,
  output logic [7:0]  rdata,
  output logic        chip_rst,
  output logic        rst_out_n
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic [CNT_W-1:0] count;
  logic             run;
  logic [PW-1:0]    pulse_left;
  logic             flag, oe, armed;

  wire key_ok   = (wdata[15:8] == KEY);
  wire ctl_wr   = wr_en & ~sel_stat & key_ok;
  wire stat_wr  = wr_en & sel_stat;
  wire overflow = run & (count == '1);

  assign chip_rst  = (pulse_left != '0);
  assign rst_out_n = ~(chip_rst & oe);
  assign rdata     = sel_stat ? {flag, oe, 6'h3F} : 8'(count);

  always_ff @(posedge clk or negedge ext_rst_n) begin
    if (!ext_rst_n) begin
      count <= '0;
      run   <= 1'b0;
    end else if (overflow || chip_rst) begin
      count <= '0;
      run   <= 1'b0;
    end else if (ctl_wr) begin
      count <= '0;
      run   <= wdata[7];
    end else if (run) begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge ext_rst_n) begin
    if (!ext_rst_n)           pulse_left <= '0;
    else if (overflow)        pulse_left <= PW'(PULSE_LEN);
    else if (chip_rst)        pulse_left <= pulse_left - 1'b1;
  end

  always_ff @(posedge clk or negedge ext_rst_n) begin
    if (!ext_rst_n) begin
      flag  <= 1'b0;
      oe    <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (overflow)
        flag <= 1'b1;
      else if (stat_wr && key_ok && !wdata[7] && armed)
        flag <= 1'b0;

      if (stat_wr && key_ok)
        oe <= wdata[6];

      if (chip_rst || stat_wr)
        armed <= 1'b0;
      else if (rd_en && sel_stat && flag)
        armed <= 1'b1;
    end
  end
endmodule

module wdt_rstctl_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             ext_rst_n,
  input logic             sel_stat,
  input logic             wr_en,
  input logic [CNT_W-1:0] count,
  input logic             run,
  input logic             flag,
  input logic             oe,
  input logic             chip_rst
);
  AST_PULSE_START: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (run && count == '1) |=> chip_rst);                                     // R5
  AST_FLAG_ON_PULSE: assert property (@(posedge clk) disable iff (!ext_rst_n)
    $rose(chip_rst) |-> flag);                                              // R6
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (flag && !(wr_en && sel_stat)) |=> flag);                               // R9
  AST_FLAG_NO_SET: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (!flag && !(run && count == '1)) |=> !flag);                            // R10
  AST_OE_HOLD: assert property (@(posedge clk) disable iff (!ext_rst_n)
    !(wr_en && sel_stat) |=> $stable(oe));                                  // R12
  AST_PULSE_CLEARS: assert property (@(posedge clk) disable iff (!ext_rst_n)
    chip_rst |-> (count == '0 && !run));                                    // R7
  AST_RUN_STEP: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (run && !chip_rst && count != '1 && !(wr_en && !sel_stat))
      |=> count == CNT_W'($past(count) + 1'b1));                            // R3
endmodule

bind wdt_rstctl wdt_rstctl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .ext_rst_n(ext_rst_n), .sel_stat(sel_stat), .wr_en(wr_en),
  .count(count), .run(run), .flag(flag), .oe(oe), .chip_rst(chip_rst)
);

// File: tb/wdt_rstctl_bench.sv
module wdt_rstctl_bench;
  logic        clk = 1'b0;
  logic        ext_rst_n = 1'b0;
  logic        sel_stat = 1'b0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [7:0]  rdata;
  logic        chip_rst, rst_out_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  wdt_rstctl u_wdt_rstctl (
    .clk(clk), .ext_rst_n(ext_rst_n), .sel_stat(sel_stat), .rd_en(rd_en),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .chip_rst(chip_rst),
    .rst_out_n(rst_out_n)
  );

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cycles);
      report();
    end
  end

  // monitor: pops expected read data and compares
  always @(negedge clk) begin
    if (rd_en) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read: actual %02h expected none", rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s read: actual %02h expected %02h", t, rdata, e);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic s, input logic [15:0] d);
    sel_stat = s; wdata = d; wr_en = 1'b1;
    idle(1);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic s, input logic [7:0] e, input string t);
    sel_stat = s; rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    idle(1);
    rd_en = 1'b0;
  endtask

  task automatic pin(input string t, input logic a, input logic e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s pin: actual %0b expected %0b", t, a, e);
    end
  endtask

  // start at a cycle right after a keyed run write; checks the 16-cycle pulse
  task automatic overflow_run(input logic oe_on);
    wr(1'b0, 16'h5A80);
    idle(255);
    pin("R5 before wrap", chip_rst, 1'b0);
    idle(1);
    for (int i = 0; i < 16; i++) begin
      pin("R5 pulse", chip_rst, 1'b1);
      pin("R8 ext out", rst_out_n, !oe_on);
      idle(1);
    end
    pin("R5 pulse end", chip_rst, 1'b0);
    pin("R8 ext release", rst_out_n, 1'b1);
  endtask

  initial begin
    idle(3);
    pin("R1 chip_rst", chip_rst, 1'b0);
    pin("R1 rst_out_n", rst_out_n, 1'b1);
    ext_rst_n = 1'b1;
    idle(1);
    rd(1'b1, 8'h3F, "R1 status");
    rd(1'b0, 8'h00, "R1 count");

    wr(1'b1, 16'h0040);                   // bad key
    rd(1'b1, 8'h3F, "R12 bad key oe");
    wr(1'b1, 16'h5A40);
    rd(1'b1, 8'h7F, "R2 oe set");

    wr(1'b0, 16'h1280);                   // bad key, no run
    idle(3);
    rd(1'b0, 8'h00, "R4 bad key ctl");
    wr(1'b0, 16'h5A80);
    idle(5);
    rd(1'b0, 8'h05, "R3 count 5");
    rd(1'b0, 8'h06, "R3 count 6");
    wr(1'b0, 16'h5A00);
    idle(4);
    rd(1'b0, 8'h00, "R4 stop clears");

    overflow_run(1'b1);
    rd(1'b0, 8'h00, "R7 count after pulse");
    idle(3);
    rd(1'b0, 8'h00, "R7 run cleared");
    wr(1'b1, 16'h5A40);                   // no prior read
    rd(1'b1, 8'hFF, "R10 write0 unqualified");   // arms
    wr(1'b1, 16'h0000);                   // bad key, cancels
    wr(1'b1, 16'h5A40);
    rd(1'b1, 8'hFF, "R11 cancelled qual");       // arms
    wr(1'b1, 16'h5AC0);                   // write 1 to flag
    rd(1'b1, 8'hFF, "R10 write1");               // arms
    wr(1'b1, 16'h5A00);
    rd(1'b1, 8'h3F, "R9 flag cleared");          // flag 0, must not arm

    overflow_run(1'b0);
    wr(1'b1, 16'h5A00);
    rd(1'b1, 8'hBF, "R9 stale read no qual");
    rd(1'b1, 8'hBF, "R6 flag kept oe off");

    ext_rst_n = 1'b0;
    idle(2);
    ext_rst_n = 1'b1;
    idle(1);
    rd(1'b1, 8'h3F, "R1 pin reset clears");
    idle(2);
    report();
  end
endmodule